// File: doc/BRIEF.md
# Presettable Synchronous BCD Decade Counter

A four-bit decade counter that steps through the decimal digits 0 to 9, coded 8421, on each rising clock edge. A parallel preset loads any four-bit value. Two count enables act together: a parallel enable shared by all stages and a trickle enable that forms the carry chain. A terminal-count output flags the last digit so that several instances can be chained into a multi-digit decimal counter.

The build parameter `ASYNC_RESET` sets the reset style of the single active-low reset pin `rst_ni`. When it is 1, the pin clears the count at once without a clock. When it is 0, the pin is sampled like any other control and clears the count on the next rising edge. The control modes have a fixed order of precedence: reset first, then load, then count, then hold. To chain stages, feed each stage's terminal count into the trickle enable of the next stage. All stages share the clock, the preset control and the parallel enable.

Top module: `bcd_decade_counter`

## Requirements
- R1: With `rst_ni`, `load_ni`, `cnt_en_p_i` and `cnt_en_t_i` all high at a rising edge, a count of 0 to 8 increases by exactly one.
- R2: A count of 9 (4'b1001) that is counting goes to 0 (4'b0000) at the rising edge.
- R3: With `ASYNC_RESET`=1, a low `rst_ni` forces `count_o` to 0 with no clock edge, and `count_o` stays 0 while `rst_ni` is low, whatever the other inputs are.
- R4: With `ASYNC_RESET`=0, a low `rst_ni` leaves `count_o` unchanged until the next rising edge. At that edge it clears `count_o` to 0, overriding load and count.
- R5: When reset is inactive, a low `load_ni` at a rising edge copies `data_i` into `count_o`, whatever the enables are.
- R6: When reset is inactive and `load_ni` is high, the count holds if either `cnt_en_p_i` or `cnt_en_t_i` is low.
- R7: `tc_o` is combinational and equals `cnt_en_t_i` AND (`count_o` == 9). It does not depend on `cnt_en_p_i`.
- R8: In a two-stage chain, with the low stage's `tc_o` feeding the high stage's `cnt_en_t_i`, the pair counts 00 to 99 and returns from 99 to 00 in a single clock.
- R9: After a load of a value from 10 to 15, counting proceeds in binary up to 15 and then to 0. `tc_o` stays low in states 10 to 15.
- R10: Changes on `load_ni`, the enables, `data_i` or the synchronous `rst_ni` between rising edges do not change `count_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; all synchronous changes happen on its rising edge |
| rst_ni | input | 1 | Active-low reset; asynchronous or synchronous according to `ASYNC_RESET` |
| load_ni | input | 1 | Active-low parallel preset |
| cnt_en_p_i | input | 1 | Parallel count enable |
| cnt_en_t_i | input | 1 | Trickle count enable; also gates `tc_o` |
| data_i | input | 4 | Preset value |
| count_o | output | 4 | Current count |
| tc_o | output | 1 | Terminal count: trickle enable high and count equal to 9 |

## Verification
The bench builds one instance with `ASYNC_RESET`=1 and one with `ASYNC_RESET`=0. Both are driven by the same stimulus, so the two reset styles can be compared within a single clock period. The asynchronous instance must clear at once, and the synchronous one must keep its value until the next edge. A separate pair of asynchronous-reset instances is chained as two decades, which brings the full 00-to-99 sequence and the 99-to-00 rollover within reach. Random presets include values from 10 to 15, which drives both instances into the binary run through 15.

// File: rtl/bcd_cnt_pkg.sv
package bcd_cnt_pkg;
  localparam int unsigned DIG_W      = 4;
  localparam logic [DIG_W-1:0] DIG_MAX = DIG_W'(9);

  typedef logic [DIG_W-1:0] digit_t;

  typedef enum logic [1:0] {
    MODE_RESET = 2'd0,
    MODE_LOAD  = 2'd1,
    MODE_COUNT = 2'd2,
    MODE_HOLD  = 2'd3
  } mode_e;

  // BCD step; codes 10..15 climb in binary and roll to 0 from 15
  function automatic digit_t next_digit(digit_t q);
    return (q == DIG_MAX) ? '0 : q + 1'b1;
  endfunction
endpackage

// File: rtl/bcd_mode_dec.sv
module bcd_mode_dec
  import bcd_cnt_pkg::*;
#(
  parameter bit ASYNC_RESET = 1'b1
) (
  input  logic  rst_ni,
  input  logic  load_ni,
  input  logic  cnt_en_p_i,
  input  logic  cnt_en_t_i,
  output mode_e mode_o
);
  logic sync_clr;

  generate
    if (ASYNC_RESET) begin : g_async
      assign sync_clr = 1'b0;  // flop handles it directly
    end else begin : g_sync
      assign sync_clr = ~rst_ni;
    end
  endgenerate

  always_comb begin
    if (sync_clr)                       mode_o = MODE_RESET;
    else if (!load_ni)                  mode_o = MODE_LOAD;
    else if (cnt_en_p_i && cnt_en_t_i)  mode_o = MODE_COUNT;
    else                                mode_o = MODE_HOLD;
  end
endmodule

// File: rtl/bcd_digit_reg.sv
module bcd_digit_reg
  import bcd_cnt_pkg::*;
#(
  parameter bit ASYNC_RESET = 1'b1
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  mode_e  mode_i,
  input  digit_t data_i,
  output digit_t q_o
);
  digit_t q_d;

  always_comb begin
    unique case (mode_i)
      MODE_RESET: q_d = '0;
      MODE_LOAD:  q_d = data_i;
      MODE_COUNT: q_d = next_digit(q_o);
      default:    q_d = q_o;
    endcase
  end

  generate
    if (ASYNC_RESET) begin : g_async
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q_o <= '0;
        else         q_o <= q_d;
      end

      AST_ASYNC_CLEAR: assert property (@(posedge clk_i)
        !rst_ni |-> q_o == '0);  // R3
    end else begin : g_sync
      always_ff @(posedge clk_i) q_o <= q_d;

      AST_SYNC_CLEAR: assert property (@(posedge clk_i)
        !rst_ni |=> q_o == '0);  // R4
    end
  endgenerate

  AST_LOAD_TAKES_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_i == MODE_LOAD |=> q_o == $past(data_i));  // R5
  AST_HOLD_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_i == MODE_HOLD |=> $stable(q_o));  // R6
  AST_WRAP_NINE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_COUNT && q_o == DIG_MAX) |=> q_o == '0);  // R2
endmodule

// File: rtl/bcd_decade_counter.sv
module bcd_decade_counter
  import bcd_cnt_pkg::*;
#(
  parameter bit ASYNC_RESET = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_ni,
  input  logic             cnt_en_p_i,
  input  logic             cnt_en_t_i,
  input  logic [DIG_W-1:0] data_i,
  output logic [DIG_W-1:0] count_o,
  output logic             tc_o
);
  mode_e  mode;
  digit_t q;

  bcd_mode_dec #(.ASYNC_RESET(ASYNC_RESET)) i_mode_dec (
    .rst_ni     (rst_ni),
    .load_ni    (load_ni),
    .cnt_en_p_i (cnt_en_p_i),
    .cnt_en_t_i (cnt_en_t_i),
    .mode_o     (mode)
  );

  bcd_digit_reg #(.ASYNC_RESET(ASYNC_RESET)) i_digit_reg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .mode_i (mode),
    .data_i (data_i),
    .q_o    (q)
  );

  assign count_o = q;
  // carry-out ignores the parallel enable so a chain ripples in one clock
  assign tc_o    = cnt_en_t_i && (q == DIG_MAX);

  AST_CARRY_ROLLS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tc_o && load_ni && cnt_en_p_i) |=> count_o == '0);  // R8
  AST_TC_NEEDS_TRICKLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tc_o |-> cnt_en_t_i);  // R7
endmodule

// File: tb/test_bcd_decade_counter.sv
module test_bcd_decade_counter;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ld_n = 1'b1;
  logic       cep = 1'b0;
  logic       cet = 1'b0;
  logic [3:0] din = 4'd0;
  logic [3:0] cnt_a, cnt_s;
  logic       tc_a, tc_s;

  logic       c_rst_n = 1'b0;
  logic       c_ld_n = 1'b1;
  logic       c_en = 1'b0;
  logic [3:0] lo_q, hi_q;
  logic       lo_tc, hi_tc;

  int n_chk = 0;
  int n_fail = 0;
  logic [3:0] q_m;  // model shared by both reset styles at edge sampling

  always #(CLK_PERIOD/2) clk = ~clk;

  bcd_decade_counter #(.ASYNC_RESET(1'b1)) i_bcd_decade_counter (
    .clk_i(clk), .rst_ni(rst_n), .load_ni(ld_n), .cnt_en_p_i(cep),
    .cnt_en_t_i(cet), .data_i(din), .count_o(cnt_a), .tc_o(tc_a));

  bcd_decade_counter #(.ASYNC_RESET(1'b0)) i_bcd_decade_counter_sync (
    .clk_i(clk), .rst_ni(rst_n), .load_ni(ld_n), .cnt_en_p_i(cep),
    .cnt_en_t_i(cet), .data_i(din), .count_o(cnt_s), .tc_o(tc_s));

  bcd_decade_counter #(.ASYNC_RESET(1'b1)) i_lo (
    .clk_i(clk), .rst_ni(c_rst_n), .load_ni(c_ld_n), .cnt_en_p_i(1'b1),
    .cnt_en_t_i(c_en), .data_i(4'd0), .count_o(lo_q), .tc_o(lo_tc));

  bcd_decade_counter #(.ASYNC_RESET(1'b1)) i_hi (
    .clk_i(clk), .rst_ni(c_rst_n), .load_ni(c_ld_n), .cnt_en_p_i(1'b1),
    .cnt_en_t_i(lo_tc), .data_i(4'd0), .count_o(hi_q), .tc_o(hi_tc));

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [3:0] ref_next(logic [3:0] q, logic r, logic l,
                                          logic p, logic t, logic [3:0] d);
    if (!r)         return 4'd0;
    else if (!l)    return d;
    else if (p && t) return (q == 4'd9) ? 4'd0 : q + 4'd1;
    else            return q;
  endfunction

  function automatic logic ref_tc(logic [3:0] q, logic t);
    return t && (q == 4'd9);
  endfunction

  // called at negedge with inputs applied; checks after the next edge
  task automatic cyc(string req);
    @(posedge clk);
    q_m = ref_next(q_m, rst_n, ld_n, cep, cet, din);
    @(negedge clk);
    chk(req, cnt_a, q_m);
    chk(req, cnt_s, q_m);
    chk({req, "/R7 tc"}, tc_a, ref_tc(q_m, cet));
    chk({req, "/R7 tc"}, tc_s, ref_tc(q_m, cet));
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    q_m = 4'd0;
    @(negedge clk);
    cyc("R4 reset state");
    rst_n = 1'b1;
    cep = 1'b1; cet = 1'b1;
    // R1 / R2: full decade and wrap
    for (int i = 0; i < 12; i++) cyc("R1 R2 count");
    // R6: each enable low holds
    cep = 1'b0; cyc("R6 cep low hold"); cyc("R6 cep low hold");
    cep = 1'b1; cet = 1'b0; cyc("R6 cet low hold");
    // R5 load overrides counting
    cet = 1'b1; ld_n = 1'b0; din = 4'd9; cyc("R5 load");
    // R7 tc independent of cep
    ld_n = 1'b1; cep = 1'b0; #1;
    chk("R7 tc cep low", tc_a, 1);
    cet = 1'b0; #1;
    chk("R7 tc cet low", tc_a, 0);
    @(negedge clk);
    cep = 1'b1; cet = 1'b1; cyc("R2 wrap after load");
    // R9 non-BCD load
    ld_n = 1'b0; din = 4'd13; cyc("R9 load 13");
    ld_n = 1'b1;
    cyc("R9 to 14"); chk("R9 tc low", tc_a, 0);
    cyc("R9 to 15"); chk("R9 tc low", tc_a, 0);
    cyc("R9 to 0");
    cyc("R9 then 1");
    // R10: wiggle sync controls mid-cycle, no change before edge
    #1; ld_n = 1'b0; din = 4'd7; #1; cep = 1'b0; #1; ld_n = 1'b1; cep = 1'b1; #1;
    chk("R10 no change between edges", cnt_s, q_m);
    chk("R10 no change between edges", cnt_a, q_m);
    @(negedge clk);
    // R3 vs R4: reset asserted mid-cycle
    ld_n = 1'b0; din = 4'd6; cyc("R5 load 6");
    ld_n = 1'b1; rst_n = 1'b0; #2;
    chk("R3 async clears at once", cnt_a, 0);
    chk("R4 sync waits for edge", cnt_s, 6);
    ld_n = 1'b0; din = 4'd5; #1;
    chk("R3 reset overrides load", cnt_a, 0);
    @(negedge clk);
    cyc("R4 sync clear over load");
    rst_n = 1'b1; ld_n = 1'b1;
    // random mix
    for (int i = 0; i < 600; i++) begin
      rst_n = ($urandom % 16) != 0;
      ld_n  = ($urandom % 4) != 0;
      cep   = ($urandom % 4) != 0;
      cet   = ($urandom % 4) != 0;
      din   = 4'($urandom);
      cyc("R1 R5 R6 R9 random");
    end
    rst_n = 1'b1; ld_n = 1'b1;

    // R8 cascade
    c_rst_n = 1'b0;
    @(negedge clk);
    c_rst_n = 1'b1; c_en = 1'b1;
    for (int n = 1; n <= 130; n++) begin
      @(negedge clk);
      chk("R8 cascade value", int'(hi_q) * 10 + int'(lo_q), n % 100);
      if (n % 100 == 99) chk("R8 low tc at 99", lo_tc, 1);
    end
    c_en = 1'b0;
    @(negedge clk);
    chk("R8 cascade holds", int'(hi_q) * 10 + int'(lo_q), 30);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule